// File: doc/BRIEF.md
# Snooping Three-State Cache Coherence Controller

This block is the coherence engine for one private cache in a small shared-bus multiprocessor. The cache is direct-mapped and write-back, and each block holds one word. Every line is in one of three states: invalid, shared, or exclusive. A shared line is clean, read-only, and may also sit in peer caches. An exclusive line is the only copy, and it is dirty and writable. The processor side issues one read or write at a time, holds its request until `cpu_done` pulses, and gets read data on `cpu_rdata`.

When the processor misses, the controller raises a bus request and waits for grant. It then re-examines the line, because a peer may have changed it while the request waited. If an exclusive victim is being replaced, the controller first writes it back. It then places a read-miss or write-miss command and fills the line from the returned data.

When the controller is not the bus master, it watches every peer command. On a matching write miss it gives up its copy. If it owns the line dirty when a peer misses on it, it claims the transaction and drives the block in place of memory. The array is written only by the granted miss cycle, by a hit that needs no bus, or by a snoop. A snoop wins the single lookup slot over a new processor request.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: After reset, every line is invalid and `bus_req`, `cpu_done`, `snp_abort` are low, and `bus_cmd_o` is 00.
- R2: A processor read to a line that is invalid, or that holds another tag, issues bus command 01 (read miss) with the requested address and leaves the line shared.
- R3: A read hit on a shared or exclusive line, and a write hit on an exclusive line, complete with no bus command.
- R4: A processor write to an invalid or shared line issues command 10 (write miss) and leaves the line exclusive. `cpu_done` is a single-cycle pulse.
- R5: A miss that displaces an exclusive line of a different tag first issues command 11 (write-back). That command carries the old address (old tag over the index) and the old data. The miss command follows in the very next cycle.
- R6: A miss that displaces a shared line issues no write-back.
- R7: A peer write miss (10) to a matching line turns a shared copy invalid. An exclusive copy asserts `snp_abort`, drives its data on `snp_data`, and becomes invalid.
- R8: A peer read miss (01) to a matching exclusive line asserts `snp_abort` in the same cycle, drives its data on `snp_data`, and leaves the line shared. `snp_abort` is never raised while this controller holds grant or for commands 00 and 11.
- R9: The array is not changed for a miss until grant. A snoop that arrives while the request waits is applied first, and the request then proceeds from the updated line state.
- R10: When a peer command (01, 10 or 11) is on the bus in the cycle a new processor request would be looked up, the lookup waits one cycle. A read hit then takes two cycles to `cpu_done` instead of one.
- R11: Every processor read returns the value most recently written to that address by any cache, or 0 if none was written.
- R12: `bus_cmd_o` is non-idle only while `bus_gnt` is high, and `bus_req` stays high from its rise until the transaction's last command has been issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor access request, held until done |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Word address; low bits select the line |
| cpu_wdata | input | DW | Write data |
| cpu_rdata | output | DW | Read data, valid with `cpu_done` |
| cpu_done | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant, held while `bus_req` stays high |
| bus_cmd_o | output | 2 | Issued command: 00 idle, 01 read miss, 10 write miss, 11 write-back |
| bus_addr_o | output | AW | Issued address, zero when idle |
| bus_data_o | output | DW | Write-back data, zero otherwise |
| bus_cmd_i | input | 2 | Command currently on the shared bus |
| bus_addr_i | input | AW | Address currently on the shared bus |
| bus_fill_i | input | DW | Fill data for the current miss (owner or memory) |
| snp_abort | output | 1 | This cache claims the current peer miss |
| snp_data | output | DW | Owner data while `snp_abort` is high, zero otherwise |

## Verification
The bench builds two instances with the default parameters: four lines, 16-bit addresses and 32-bit words. It connects them through a fixed-priority arbiter and a word memory. With only four lines, addresses one line-stride apart collide in the same slot. That makes write-backs, shared replacements and owner interventions reachable with a handful of addresses. The bench can also start both processors together, so a request waiting for grant is invalidated by its peer, and it can line up a processor lookup exactly with a peer's bus cycle to measure the stall.

// File: rtl/msi_pkg.sv
package msi_pkg;
  typedef enum logic [1:0] {
    LS_INV = 2'b00,
    LS_SHR = 2'b01,
    LS_EXC = 2'b10
  } line_st_e;

  typedef enum logic [1:0] {
    BC_IDLE   = 2'b00,
    BC_RDMISS = 2'b01,
    BC_WRMISS = 2'b10,
    BC_WB     = 2'b11
  } bus_cmd_e;

  typedef enum logic [2:0] {
    C_IDLE = 3'd0,
    C_ARB  = 3'd1,
    C_WB   = 3'd2,
    C_MISS = 3'd3,
    C_DONE = 3'd4
  } ctl_e;
endpackage

// File: rtl/msi_line_store.sv
module msi_line_store
  import msi_pkg::*;
#(
  parameter int LINES = 4,
  parameter int IW    = 2,
  parameter int TW    = 14,
  parameter int DW    = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IW-1:0]   a_idx,
  output line_st_e        a_st,
  output logic [TW-1:0]   a_tag,
  output logic [DW-1:0]   a_data,
  input  logic [IW-1:0]   b_idx,
  output line_st_e        b_st,
  output logic [TW-1:0]   b_tag,
  output logic [DW-1:0]   b_data,
  input  logic            w_en,
  input  logic [IW-1:0]   w_idx,
  input  line_st_e        w_st,
  input  logic [TW-1:0]   w_tag,
  input  logic [DW-1:0]   w_data
);
  line_st_e      st_q   [LINES];
  logic [TW-1:0] tag_q  [LINES];
  logic [DW-1:0] data_q [LINES];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic hit_w;
    assign hit_w = w_en && (w_idx == IW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     st_q[i] <= LS_INV;
      else if (hit_w) st_q[i] <= w_st;
    end

    always_ff @(posedge clk) begin
      if (hit_w) begin
        tag_q[i]  <= w_tag;
        data_q[i] <= w_data;
      end
    end
  end

  assign a_st   = st_q[a_idx];
  assign a_tag  = tag_q[a_idx];
  assign a_data = data_q[a_idx];
  assign b_st   = st_q[b_idx];
  assign b_tag  = tag_q[b_idx];
  assign b_data = data_q[b_idx];
endmodule

// File: rtl/msi_snoop_resp.sv
module msi_snoop_resp
  import msi_pkg::*;
#(
  parameter int TW = 14
) (
  input  logic [1:0]    bus_cmd,
  input  logic          bus_gnt,
  input  line_st_e      line_st,
  input  logic [TW-1:0] line_tag,
  input  logic [TW-1:0] bus_tag,
  output logic          active,
  output logic          upd,
  output line_st_e      new_st,
  output logic          abort
);
  logic match;

  assign active = (bus_cmd != BC_IDLE) && !bus_gnt;
  assign match  = active && (line_st != LS_INV) && (line_tag == bus_tag);

  always_comb begin
    upd    = 1'b0;
    abort  = 1'b0;
    new_st = line_st;
    if (match) begin
      unique case (bus_cmd)
        BC_RDMISS: if (line_st == LS_EXC) begin
          upd    = 1'b1;
          abort  = 1'b1;
          new_st = LS_SHR;
        end
        BC_WRMISS: begin
          upd    = 1'b1;
          abort  = (line_st == LS_EXC);
          new_st = LS_INV;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl
  import msi_pkg::*;
#(
  parameter int LINES = 4,
  parameter int DW    = 32,
  parameter int AW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          cpu_done,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic [1:0]    bus_cmd_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_data_o,
  input  logic [1:0]    bus_cmd_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_fill_i,
  output logic          snp_abort,
  output logic [DW-1:0] snp_data
);
  localparam int IW = $clog2(LINES);
  localparam int TW = AW - IW;

  ctl_e          ctl_q, ctl_n;
  logic [DW-1:0] rdata_q, rdata_n;
  logic          rd_load;

  logic [IW-1:0] cpu_idx, b_idx;
  logic [TW-1:0] cpu_tag, b_btag;
  line_st_e      a_st, b_st, snp_st, cw_st, w_st;
  logic [TW-1:0] a_tag, b_tag, w_tag;
  logic [DW-1:0] a_data, b_data, cw_data, w_data;
  logic          snp_active, snp_upd, snp_claim, cpu_wr, cpu_hit, w_en;
  logic [IW-1:0] w_idx;
  bus_cmd_e      cmd_d;

  assign cpu_idx = cpu_addr[IW-1:0];
  assign cpu_tag = cpu_addr[AW-1:IW];
  assign b_idx   = bus_addr_i[IW-1:0];
  assign b_btag  = bus_addr_i[AW-1:IW];

  msi_line_store #(.LINES(LINES), .IW(IW), .TW(TW), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .a_idx(cpu_idx), .a_st(a_st), .a_tag(a_tag), .a_data(a_data),
    .b_idx(b_idx), .b_st(b_st), .b_tag(b_tag), .b_data(b_data),
    .w_en(w_en), .w_idx(w_idx), .w_st(w_st), .w_tag(w_tag), .w_data(w_data)
  );

  msi_snoop_resp #(.TW(TW)) u_snoop (
    .bus_cmd(bus_cmd_i), .bus_gnt(bus_gnt),
    .line_st(b_st), .line_tag(b_tag), .bus_tag(b_btag),
    .active(snp_active), .upd(snp_upd), .new_st(snp_st), .abort(snp_claim)
  );

  assign cpu_hit = (a_st != LS_INV) && (a_tag == cpu_tag);

  // single write port: a snoop and a CPU write never coincide
  assign w_en   = snp_upd | cpu_wr;
  assign w_idx  = snp_upd ? b_idx  : cpu_idx;
  assign w_st   = snp_upd ? snp_st : cw_st;
  assign w_tag  = snp_upd ? b_tag  : cpu_tag;
  assign w_data = snp_upd ? b_data : cw_data;

  assign snp_abort = snp_claim;
  assign snp_data  = snp_claim ? b_data : '0;

  always_comb begin
    ctl_n      = ctl_q;
    rdata_n    = rdata_q;
    rd_load    = 1'b0;
    cpu_wr     = 1'b0;
    cw_st      = LS_INV;
    cw_data    = cpu_wdata;
    cmd_d      = BC_IDLE;
    bus_addr_o = '0;
    bus_data_o = '0;
    unique case (ctl_q)
      C_IDLE: begin
        if (cpu_req && !snp_active) begin
          if (!cpu_we && cpu_hit) begin
            rdata_n = a_data;
            rd_load = 1'b1;
            ctl_n   = C_DONE;
          end else if (cpu_we && cpu_hit && (a_st == LS_EXC)) begin
            cpu_wr = 1'b1;
            cw_st  = LS_EXC;
            ctl_n  = C_DONE;
          end else begin
            ctl_n = C_ARB;
          end
        end
      end
      C_ARB: begin
        if (bus_gnt)
          ctl_n = ((a_st == LS_EXC) && (a_tag != cpu_tag)) ? C_WB : C_MISS;
      end
      C_WB: begin
        cmd_d      = BC_WB;
        bus_addr_o = {a_tag, cpu_idx};
        bus_data_o = a_data;
        ctl_n      = C_MISS;
      end
      C_MISS: begin
        cmd_d      = cpu_we ? BC_WRMISS : BC_RDMISS;
        bus_addr_o = cpu_addr;
        cpu_wr     = 1'b1;
        cw_st      = cpu_we ? LS_EXC : LS_SHR;
        cw_data    = cpu_we ? cpu_wdata : bus_fill_i;
        rdata_n    = bus_fill_i;
        rd_load    = !cpu_we;
        ctl_n      = C_DONE;
      end
      C_DONE:  ctl_n = C_IDLE;
      default: ctl_n = C_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= C_IDLE;
    else        ctl_q <= ctl_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (rd_load) rdata_q <= rdata_n;
  end

  assign bus_cmd_o = cmd_d;
  assign bus_req   = (ctl_q == C_ARB) || (ctl_q == C_WB) || (ctl_q == C_MISS);
  assign cpu_done  = (ctl_q == C_DONE);
  assign cpu_rdata = rdata_q;
endmodule

// File: rtl/msi_snoop_ctrl_chk.sv
module msi_snoop_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_done,
  input logic       bus_req,
  input logic       bus_gnt,
  input logic [1:0] bus_cmd_o,
  input logic [1:0] bus_cmd_i,
  input logic       snp_abort
);
  a_r12_cmd_only_granted: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd_o != 2'b00) |-> bus_gnt);

  a_r12_req_kept_waiting: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> bus_req);

  a_r8_abort_peer_miss_only: assert property (@(posedge clk) disable iff (!rst_n)
    snp_abort |-> (!bus_gnt && ((bus_cmd_i == 2'b01) || (bus_cmd_i == 2'b10))));

  a_r5_wb_then_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd_o == 2'b11) |=> ((bus_cmd_o == 2'b01) || (bus_cmd_o == 2'b10)));

  a_r4_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done);
endmodule

bind msi_snoop_ctrl msi_snoop_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_done(cpu_done), .bus_req(bus_req),
  .bus_gnt(bus_gnt), .bus_cmd_o(bus_cmd_o), .bus_cmd_i(bus_cmd_i),
  .snp_abort(snp_abort)
);

// File: tb/sim_msi_snoop_ctrl.sv
module sim_msi_snoop_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk, rst_n;
  logic        cpu_req  [2];
  logic        cpu_we   [2];
  logic [15:0] cpu_addr [2];
  logic [31:0] cpu_wdata[2];
  logic [31:0] cpu_rdata[2];
  logic        cpu_done [2];
  logic        breq     [2];
  logic [1:0]  gnt;
  logic [1:0]  cmd_o    [2];
  logic [15:0] addr_o   [2];
  logic [31:0] data_o   [2];
  logic        abort    [2];
  logic [31:0] sdata    [2];

  logic [1:0]  sh_cmd;
  logic [15:0] sh_addr;
  logic [31:0] sh_data, sh_fill;
  logic        sh_abort;
  logic [31:0] sysmem [1024];

  int tests, fails;

  assign sh_cmd   = cmd_o[0] | cmd_o[1];
  assign sh_addr  = addr_o[0] | addr_o[1];
  assign sh_data  = data_o[0] | data_o[1];
  assign sh_abort = abort[0] | abort[1];
  assign sh_fill  = sh_abort ? (sdata[0] | sdata[1]) : sysmem[sh_addr[9:0]];

  msi_snoop_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req[0]), .cpu_we(cpu_we[0]),
    .cpu_addr(cpu_addr[0]), .cpu_wdata(cpu_wdata[0]), .cpu_rdata(cpu_rdata[0]),
    .cpu_done(cpu_done[0]), .bus_req(breq[0]), .bus_gnt(gnt[0]),
    .bus_cmd_o(cmd_o[0]), .bus_addr_o(addr_o[0]), .bus_data_o(data_o[0]),
    .bus_cmd_i(sh_cmd), .bus_addr_i(sh_addr), .bus_fill_i(sh_fill),
    .snp_abort(abort[0]), .snp_data(sdata[0]));

  msi_snoop_ctrl u1 (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req[1]), .cpu_we(cpu_we[1]),
    .cpu_addr(cpu_addr[1]), .cpu_wdata(cpu_wdata[1]), .cpu_rdata(cpu_rdata[1]),
    .cpu_done(cpu_done[1]), .bus_req(breq[1]), .bus_gnt(gnt[1]),
    .bus_cmd_o(cmd_o[1]), .bus_addr_o(addr_o[1]), .bus_data_o(data_o[1]),
    .bus_cmd_i(sh_cmd), .bus_addr_i(sh_addr), .bus_fill_i(sh_fill),
    .snp_abort(abort[1]), .snp_data(sdata[1]));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // fixed-priority arbiter, grant held while the owner keeps requesting
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) gnt <= 2'b00;
    else if (gnt == 2'b00) begin
      if (breq[0])      gnt <= 2'b01;
      else if (breq[1]) gnt <= 2'b10;
    end else if (!((gnt[0] && breq[0]) || (gnt[1] && breq[1]))) gnt <= 2'b00;
  end

  // word memory: write-backs and owner interventions update it
  always @(posedge clk) begin
    if (rst_n) begin
      if (sh_cmd == 2'b11) sysmem[sh_addr[9:0]] <= sh_data;
      else if (sh_abort)   sysmem[sh_addr[9:0]] <= sdata[0] | sdata[1];
    end
  end

  // ---------------- reference model ----------------
  typedef struct {
    logic [1:0]  cmd;
    logic [15:0] addr;
    bit          ab;
    logic [31:0] val;
    string       rq;
  } exp_t;
  exp_t expq[$];
  int   mst [2][4];
  int   mtg [2][4];
  logic [31:0] gold [1024];

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic model_op(input int c, input bit we, input logic [15:0] a,
                          input logic [31:0] d, input string rq,
                          output logic [31:0] rexp);
    int idx, tag, o;
    bit hit, ab;
    exp_t e;
    idx = int'(a[1:0]);
    tag = int'(a[15:2]);
    o   = 1 - c;
    hit = (mst[c][idx] != 0) && (mtg[c][idx] == tag);
    if (!((!we && hit) || (we && hit && mst[c][idx] == 2))) begin
      if (mst[c][idx] == 2 && mtg[c][idx] != tag) begin
        e.cmd = 2'b11; e.addr = 16'((mtg[c][idx] << 2) | idx); e.ab = 0;
        e.val = gold[e.addr[9:0]]; e.rq = rq;
        expq.push_back(e);
      end
      ab = (mst[o][idx] == 2) && (mtg[o][idx] == tag);
      e.cmd = we ? 2'b10 : 2'b01; e.addr = a; e.ab = ab;
      e.val = gold[a[9:0]]; e.rq = rq;
      expq.push_back(e);
      if (mst[o][idx] != 0 && mtg[o][idx] == tag)
        mst[o][idx] = we ? 0 : 1;
      mst[c][idx] = we ? 2 : 1;
      mtg[c][idx] = tag;
    end
    rexp = gold[a[9:0]];
    if (we) gold[a[9:0]] = d;
  endtask

  // per-clock comparison of bus traffic against the model's expectations
  always @(negedge clk) begin
    if (rst_n && sh_cmd != 2'b00) begin
      if (expq.size() == 0) begin
        check(0, "R3", "unexpected bus command", 32'(sh_cmd), 0);
      end else begin
        exp_t e;
        e = expq.pop_front();
        check(sh_cmd == e.cmd, e.rq, "bus command", 32'(sh_cmd), 32'(e.cmd));
        check(sh_addr == e.addr, e.rq, "bus address", 32'(sh_addr), 32'(e.addr));
        if (e.cmd == 2'b11)
          check(sh_data == e.val, "R5", "write-back data", sh_data, e.val);
        else begin
          check(sh_abort == e.ab, e.ab ? "R8" : "R7", "owner claim",
                32'(sh_abort), 32'(e.ab));
          if (e.ab) check(sh_fill == e.val, "R8", "owner data", sh_fill, e.val);
        end
      end
    end
  end

  // caller is just past a negedge; returns just past the negedge showing done
  task automatic run_op(input int c, input bit we, input logic [15:0] a,
                        input logic [31:0] d, input logic [31:0] rexp,
                        input string rq, output int lat);
    cpu_we[c] = we; cpu_addr[c] = a; cpu_wdata[c] = d; cpu_req[c] = 1'b1;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!cpu_done[c]);
    cpu_req[c] = 1'b0;
    if (!we) check(cpu_rdata[c] == rexp, rq, "read data", cpu_rdata[c], rexp);
  endtask

  task automatic drained(input string rq);
    check(expq.size() == 0, rq, "expected bus traffic missing", expq.size(), 0);
  endtask

  task automatic seq_op(input int c, input bit we, input logic [15:0] a,
                        input logic [31:0] d, input string rq);
    logic [31:0] rexp;
    int lat;
    model_op(c, we, a, d, rq, rexp);
    run_op(c, we, a, d, rexp, rq, lat);
    drained(rq);
  endtask

  localparam logic [15:0] A1 = 16'h0005, A2 = 16'h0105, BX = 16'h0022;
  localparam logic [15:0] XA = 16'h0033, YA = 16'h0042;

  initial begin
    tests = 0; fails = 0;
    for (int i = 0; i < 1024; i++) begin sysmem[i] = '0; gold[i] = '0; end
    for (int c = 0; c < 2; c++) begin
      cpu_req[c] = 0; cpu_we[c] = 0; cpu_addr[c] = '0; cpu_wdata[c] = '0;
      for (int l = 0; l < 4; l++) begin mst[c][l] = 0; mtg[c][l] = 0; end
    end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: quiet outputs during reset
    for (int c = 0; c < 2; c++) begin
      check(!breq[c] && !cpu_done[c] && !abort[c] && cmd_o[c] == 2'b00,
            "R1", "outputs in reset", {breq[c], cpu_done[c], abort[c], cmd_o[c]}, 0);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // two-cache walk-through, A1 and A2 share a line
    seq_op(0, 1, A1, 32'd10, "R4");  // write miss, exclusive
    seq_op(0, 0, A1, 0, "R3");       // read hit, no traffic
    seq_op(1, 0, A1, 0, "R8");       // read miss claimed by owner, both shared
    seq_op(1, 1, A1, 32'd20, "R7");  // write miss invalidates shared peer
    seq_op(1, 1, A2, 32'd40, "R5");  // write-back A1 then write miss A2
    seq_op(0, 0, A1, 0, "R2");       // invalid -> read miss, memory has 20
    seq_op(0, 0, A2, 0, "R6");       // shared replaced, no write-back, owner claims
    seq_op(1, 1, A2, 32'd77, "R4");  // shared -> write miss
    seq_op(0, 1, A2, 32'd55, "R7");  // exclusive peer claims write miss
    seq_op(1, 0, A2, 0, "R11");
    seq_op(0, 1, A2, 32'd56, "R4");  // shared -> write miss again
    seq_op(0, 1, A2, 32'd57, "R3");  // exclusive write hit, no traffic
    seq_op(0, 0, A2, 0, "R3");

    // R9: both write a shared line at once; the waiting one is invalidated
    seq_op(0, 0, BX, 0, "R2");
    seq_op(1, 0, BX, 0, "R2");
    begin
      logic [31:0] e0, e1;
      int l0, l1;
      model_op(0, 1, BX, 32'd66, "R9", e0);
      model_op(1, 1, BX, 32'd88, "R9", e1);
      fork
        run_op(0, 1, BX, 32'd66, e0, "R9", l0);
        run_op(1, 1, BX, 32'd88, e1, "R9", l1);
      join
      drained("R9");
    end
    seq_op(0, 0, BX, 0, "R9");       // owner claims, value 88
    seq_op(1, 0, BX, 0, "R11");

    // R10: lookup coinciding with a peer bus command waits one cycle
    seq_op(0, 0, XA, 0, "R2");
    repeat (3) @(negedge clk);
    begin
      logic [31:0] e0, e1;
      int l0, l1;
      model_op(1, 1, YA, 32'd99, "R10", e1);
      model_op(0, 0, XA, 0, "R10", e0);
      fork
        run_op(1, 1, YA, 32'd99, e1, "R10", l1);
        begin
          repeat (3) @(negedge clk);
          run_op(0, 0, XA, 0, e0, "R10", l0);
        end
      join
      check(l0 == 2, "R10", "stalled hit latency", l0, 2);
      drained("R10");
    end
    repeat (3) @(negedge clk);
    begin
      logic [31:0] e0;
      int l0;
      model_op(0, 0, XA, 0, "R10", e0);
      run_op(0, 0, XA, 0, e0, "R10", l0);
      check(l0 == 1, "R10", "plain hit latency", l0, 1);
    end

    // R11: mixed traffic over colliding addresses
    begin
      logic [15:0] pool [8];
      int unsigned s;
      pool[0] = 16'h005; pool[1] = 16'h105; pool[2] = 16'h205; pool[3] = 16'h022;
      pool[4] = 16'h122; pool[5] = 16'h033; pool[6] = 16'h042; pool[7] = 16'h0B3;
      s = 32'h1234_5678;
      for (int i = 0; i < 60; i++) begin
        s = s * 32'd1103515245 + 32'd12345;
        seq_op(int'(s[20]), s[17], pool[s[26:24]], 32'(s[15:0]) + 32'(i), "R11");
      end
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: run did not finish actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule